// File: doc/BRIEF.md
# PLL Divider Configuration Controller

This block holds the divider settings that a clock synthesizer core uses. There are four settings: a 10-bit feedback divider M, a 3-bit output divider NA, a 1-bit output divider NB and a 1-bit prescaler P. A mode input picks where the active settings come from. In parallel mode they come from a set of strap pins. In serial mode they come from two byte-wide shadow registers and a write-only command register, which a bus front end reaches through write and read strobes.

The command register can step M up or down by one, with saturation at both ends. It can also copy the shadow registers into the active dividers, or copy the active dividers back into the shadow registers. The two mode changes are handled differently. Going from parallel to serial keeps every value as it was. Going from serial to parallel hands the active dividers back to the pins on the next clock edge. In parallel mode the shadow registers track the pin configuration and can be read but not written. A read-only lock bit, taken from the lock status input, appears in the upper shadow register.

Top module: `pll_div_ctrl`

## Requirements
- R1: While `rst_n` is low, the active M, NA, NB and P outputs are zero and `rd_data` is 0x00.
- R2: On each rising clock edge at which `serial_mode` is 0, the active dividers take the values on `pin_m`, `pin_na`, `pin_nb` and `pin_p`. This also applies to the first edge after a change from serial to parallel mode.
- R3: On a change from parallel to serial mode, the active dividers and the shadow registers keep the values they had after the last parallel edge. In serial mode the active dividers change only through a command write.
- R4: A read strobe at address 0x00 returns M[7:0] of the shadow registers. A read strobe at 0x01 returns a byte with M[9:8] in bits 1:0, NA in bits 4:2, NB in bit 5, P in bit 6 and the current `pll_lock` in bit 7. Read data appears on `rd_data` after the clock edge that samples the strobe and holds until the next read. Bit 7 of a write to 0x01 is discarded.
- R5: A command write to 0xF0 whose low nibble selects step-up (bit 0) adds one to the active M. At M = 1023 it leaves M at 1023.
- R6: A command that selects step-down (bit 1) subtracts one from the active M. At M = 0 it leaves M at 0.
- R7: A command that selects load (bit 2) copies all four shadow fields into the active dividers.
- R8: A command that selects fetch (bit 3) copies all four active divider values into the shadow registers.
- R9: Bits 7:4 of a command byte are ignored. When several of bits 3:0 are set, only the lowest-numbered set bit acts. A command byte with bits 3:0 all zero changes nothing.
- R10: A read of 0xF0, or of any address other than 0x00 and 0x01, returns 0x00. Writes to any address other than 0x00, 0x01 and 0xF0 have no effect.
- R11: In parallel mode, writes to 0x00, 0x01 and 0xF0 have no effect. The shadow registers then read back the pin configuration.
- R12: A write to 0x00 or 0x01 in serial mode changes only the shadow registers. The active dividers stay as they were until a load command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_mode | input | 1 | 0 = parallel pin source, 1 = serial register source |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Read data, updated one edge after `reg_rd` |
| pin_m | input | 10 | Parallel M setting |
| pin_na | input | 3 | Parallel NA setting |
| pin_nb | input | 1 | Parallel NB setting |
| pin_p | input | 1 | Parallel P setting |
| pll_lock | input | 1 | Lock status from the PLL |
| act_m | output | 10 | Active feedback divider M |
| act_na | output | 3 | Active output divider NA |
| act_nb | output | 1 | Active output divider NB |
| act_p | output | 1 | Active prescaler P |

## Verification
The assertions check several rules on every cycle. In parallel mode the active dividers track the pins. In serial mode the active dividers stay stable unless a command is written. Steps up and down move M by exactly one and stick at the limits. Unmapped reads return zero, and the lock bit mirrors the input. Some behaviour depends on earlier writes, and only the bench's scenarios can show it: shadow and active values exchanged through load and fetch, priority among several command bits, and values held across both mode changes.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int BYTE_W  = 8;
    localparam int M_W     = 10;
    localparam int NA_W    = 3;
    localparam int M_HI_W  = M_W - BYTE_W;
    localparam int CMD_W   = 4;

    // Bit positions inside the command byte, lowest has priority
    localparam int CMD_INC  = 0;
    localparam int CMD_DEC  = 1;
    localparam int CMD_LOAD = 2;
    localparam int CMD_GET  = 3;

    typedef struct packed {
        logic            p;
        logic            nb;
        logic [NA_W-1:0] na;
        logic [M_W-1:0]  m;
    } div_cfg_t;

    localparam int CFG_W = $bits(div_cfg_t);
endpackage

// File: rtl/pdc_cmd_decode.sv
module pdc_cmd_decode
    import pdc_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_bits,
    output logic [CMD_W-1:0] cmd_oh
);
    logic [CMD_W-1:0] below;

    // below[i] is set when any lower-numbered command bit is set
    generate
        for (genvar i = 0; i < CMD_W; i++) begin : g_pri
            if (i == 0) begin : g_first
                assign below[i] = 1'b0;
            end else begin : g_rest
                assign below[i] = below[i-1] | cmd_bits[i-1];
            end
            assign cmd_oh[i] = cmd_wr & cmd_bits[i] & ~below[i];
        end
    endgenerate
endmodule

// File: rtl/pdc_step.sv
module pdc_step #(
    parameter int W = 10
) (
    input  logic [W-1:0] val,
    input  logic         up,
    input  logic         down,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        nxt = val;
        if (up && (val != TOP)) begin
            nxt = val + 1'b1;
        end else if (down && (val != '0)) begin
            nxt = val - 1'b1;
        end
    end
endmodule

// File: rtl/pdc_rd_mux.sv
module pdc_rd_mux
    import pdc_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO = 'h00,
    parameter logic [ADDR_W-1:0] ADDR_HI = 'h01
) (
    input  logic [ADDR_W-1:0] addr,
    input  div_cfg_t          shd,
    input  logic              lock,
    output logic [BYTE_W-1:0] rbyte
);
    always_comb begin
        rbyte = '0;
        if (addr == ADDR_LO) begin
            rbyte = shd.m[BYTE_W-1:0];
        end else if (addr == ADDR_HI) begin
            rbyte = {lock, shd.p, shd.nb, shd.na, shd.m[M_W-1:BYTE_W]};
        end
    end
endmodule

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
    import pdc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = ADDR_W'('h00),
    parameter logic [ADDR_W-1:0] ADDR_HI  = ADDR_W'('h01),
    parameter logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'('hF0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [M_W-1:0]    pin_m,
    input  logic [NA_W-1:0]   pin_na,
    input  logic              pin_nb,
    input  logic              pin_p,
    input  logic              pll_lock,
    output logic [M_W-1:0]    act_m,
    output logic [NA_W-1:0]   act_na,
    output logic              act_nb,
    output logic              act_p
);
    typedef struct packed {
        div_cfg_t          act;
        div_cfg_t          shd;
        logic [BYTE_W-1:0] rdata;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    div_cfg_t          pin_cfg;
    logic              wr_lo, wr_hi, wr_cmd;
    logic [CMD_W-1:0]  cmd_oh;
    logic [M_W-1:0]    m_step;
    logic [BYTE_W-1:0] rd_byte;

    assign pin_cfg = '{p: pin_p, nb: pin_nb, na: pin_na, m: pin_m};

    // Bus writes count only in serial mode
    assign wr_lo  = serial_mode & reg_wr & (reg_addr == ADDR_LO);
    assign wr_hi  = serial_mode & reg_wr & (reg_addr == ADDR_HI);
    assign wr_cmd = serial_mode & reg_wr & (reg_addr == ADDR_CMD);

    pdc_cmd_decode u_dec (
        .cmd_wr   (wr_cmd),
        .cmd_bits (reg_wdata[CMD_W-1:0]),
        .cmd_oh   (cmd_oh)
    );

    pdc_step #(.W(M_W)) u_step (
        .val  (st_q.act.m),
        .up   (cmd_oh[CMD_INC]),
        .down (cmd_oh[CMD_DEC]),
        .nxt  (m_step)
    );

    pdc_rd_mux #(
        .ADDR_W  (ADDR_W),
        .ADDR_LO (ADDR_LO),
        .ADDR_HI (ADDR_HI)
    ) u_rmux (
        .addr  (reg_addr),
        .shd   (st_q.shd),
        .lock  (pll_lock),
        .rbyte (rd_byte)
    );

    always_comb begin
        st_d = st_q;
        if (!serial_mode) begin
            // Pins drive the dividers and the shadows mirror them
            st_d.act = pin_cfg;
            st_d.shd = pin_cfg;
        end else begin
            if (wr_lo) begin
                st_d.shd.m[BYTE_W-1:0] = reg_wdata;
            end
            if (wr_hi) begin
                st_d.shd.m[M_W-1:BYTE_W] = reg_wdata[M_HI_W-1:0];
                st_d.shd.na              = reg_wdata[M_HI_W +: NA_W];
                st_d.shd.nb              = reg_wdata[M_HI_W + NA_W];
                st_d.shd.p               = reg_wdata[M_HI_W + NA_W + 1];
            end
            if (cmd_oh[CMD_INC] || cmd_oh[CMD_DEC]) begin
                st_d.act.m = m_step;
            end
            if (cmd_oh[CMD_LOAD]) begin
                st_d.act = st_q.shd;
            end
            if (cmd_oh[CMD_GET]) begin
                st_d.shd = st_q.act;
            end
        end
        if (reg_rd) begin
            st_d.rdata = rd_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_m   = st_q.act.m;
    assign act_na  = st_q.act.na;
    assign act_nb  = st_q.act.nb;
    assign act_p   = st_q.act.p;
    assign rd_data = st_q.rdata;
endmodule

// File: rtl/pll_div_ctrl_chk.sv
module pll_div_ctrl_chk
    import pdc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              serial_mode,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] rd_data,
    input logic [M_W-1:0]    pin_m,
    input logic [NA_W-1:0]   pin_na,
    input logic              pin_nb,
    input logic              pin_p,
    input logic              pll_lock,
    input logic [M_W-1:0]    act_m,
    input logic [NA_W-1:0]   act_na,
    input logic              act_nb,
    input logic              act_p
);
    logic [CFG_W-1:0] act_all, pin_all;
    logic             cmd_w;

    assign act_all = {act_p, act_nb, act_na, act_m};
    assign pin_all = {pin_p, pin_nb, pin_na, pin_m};
    assign cmd_w   = serial_mode && reg_wr && (reg_addr == 8'hF0);

    // R2: parallel mode follows the pins
    a_r2_follow_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |=> act_all == $past(pin_all));

    // R3: serial mode holds the dividers without a command
    a_r3_hold_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && !cmd_w) |=> $stable(act_all));

    // R5: step up by one below the top
    a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && reg_wdata[0] && act_m != {M_W{1'b1}}) |=> act_m == $past(act_m) + 1'b1);

    // R5: saturate at the top
    a_r5_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && reg_wdata[0] && act_m == {M_W{1'b1}}) |=> act_m == {M_W{1'b1}});

    // R6: step down by one above zero
    a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && reg_wdata[1:0] == 2'b10 && act_m != '0) |=> act_m == $past(act_m) - 1'b1);

    // R6: saturate at zero
    a_r6_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && reg_wdata[1:0] == 2'b10 && act_m == '0) |=> act_m == '0);

    // R4: lock bit mirrors the input at read time
    a_r4_lock_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h01) |=> rd_data[7] == $past(pll_lock));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != 8'h00 && reg_addr != 8'h01) |=> rd_data == '0);
endmodule

bind pll_div_ctrl pll_div_ctrl_chk u_chk (.*);

// File: tb/pll_div_ctrl_bench.sv
module pll_div_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rd_data;
    logic [9:0] pin_m = '0;
    logic [2:0] pin_na = '0;
    logic       pin_nb = 1'b0;
    logic       pin_p = 1'b0;
    logic       pll_lock = 1'b1;
    logic [9:0] act_m;
    logic [2:0] act_na;
    logic       act_nb;
    logic       act_p;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pll_div_ctrl u_pll_div_ctrl (
        .clk, .rst_n, .serial_mode, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
        .rd_data, .pin_m, .pin_na, .pin_nb, .pin_p, .pll_lock,
        .act_m, .act_na, .act_nb, .act_p
    );

    // op: 0 write, 1 read and compare rd_data, 2 compare {p,nb,na,m}
    localparam int NV = 35;
    localparam logic [33:0] VEC [NV] = '{
        {2'd0, 8'h00, 8'hFF, 16'h0000},   // R12 shadow lo
        {2'd0, 8'h01, 8'hCF, 16'h0000},   // R12 shadow hi, bit7 dropped
        {2'd2, 8'h00, 8'h00, 16'h36A5},   // R12 active unchanged
        {2'd1, 8'h01, 8'h00, 16'h00CF},   // R4 hi layout + lock
        {2'd1, 8'h00, 8'h00, 16'h00FF},   // R4 lo
        {2'd0, 8'hF0, 8'h04, 16'h0000},   // R7 load
        {2'd2, 8'h00, 8'h00, 16'h4FFF},   // R7
        {2'd0, 8'hF0, 8'h01, 16'h0000},   // R5 inc at top
        {2'd2, 8'h00, 8'h00, 16'h4FFF},   // R5 saturate
        {2'd0, 8'hF0, 8'h02, 16'h0000},   // R6 dec
        {2'd2, 8'h00, 8'h00, 16'h4FFE},   // R6
        {2'd0, 8'hF0, 8'hF1, 16'h0000},   // R9 upper nibble ignored
        {2'd2, 8'h00, 8'h00, 16'h4FFF},   // R9 / R5
        {2'd0, 8'hF0, 8'h0E, 16'h0000},   // R9 dec wins
        {2'd2, 8'h00, 8'h00, 16'h4FFE},   // R9
        {2'd0, 8'hF0, 8'h08, 16'h0000},   // R8 get
        {2'd1, 8'h00, 8'h00, 16'h00FE},   // R8
        {2'd1, 8'h01, 8'h00, 16'h00CF},   // R8
        {2'd0, 8'h00, 8'h00, 16'h0000},   // R12
        {2'd0, 8'h01, 8'h00, 16'h0000},   // R12
        {2'd2, 8'h00, 8'h00, 16'h4FFE},   // R12 still old
        {2'd0, 8'hF0, 8'h0C, 16'h0000},   // R9 load wins over get
        {2'd2, 8'h00, 8'h00, 16'h0000},   // R7 / R9
        {2'd0, 8'hF0, 8'h02, 16'h0000},   // R6 dec at zero
        {2'd2, 8'h00, 8'h00, 16'h0000},   // R6 saturate
        {2'd0, 8'hF0, 8'h01, 16'h0000},   // R5 inc
        {2'd2, 8'h00, 8'h00, 16'h0001},   // R5
        {2'd1, 8'hF0, 8'h00, 16'h0000},   // R10 cmd unreadable
        {2'd0, 8'h02, 8'hAA, 16'h0000},   // R10 unmapped write
        {2'd1, 8'h02, 8'h00, 16'h0000},   // R10 unmapped read
        {2'd1, 8'h00, 8'h00, 16'h0000},   // R10 shadow untouched
        {2'd0, 8'hF0, 8'h00, 16'h0000},   // R9 empty command
        {2'd2, 8'h00, 8'h00, 16'h0001},   // R9
        {2'd0, 8'hF0, 8'hF0, 16'h0000},   // R9 only upper nibble
        {2'd2, 8'h00, 8'h00, 16'h0001}    // R9
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [15:0] act_word();
        return {1'b0, act_p, act_nb, act_na, act_m};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        pin_m = 10'h2A5; pin_na = 3'd5; pin_nb = 1'b1; pin_p = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset active", act_word(), 16'h0000);
        check("R1 reset rd_data", {8'h00, rd_data}, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 parallel follow", act_word(), 16'h36A5);
        do_rd(8'h01, rb);
        check("R11 shadow hi mirrors pins", {8'h00, rb}, 16'h00B6);
        do_rd(8'h00, rb);
        check("R11 shadow lo mirrors pins", {8'h00, rb}, 16'h00A5);
        do_wr(8'h00, 8'h11);
        do_wr(8'hF0, 8'h01);
        do_rd(8'h00, rb);
        check("R11 parallel write ignored", {8'h00, rb}, 16'h00A5);
        check("R11 parallel cmd ignored", act_word(), 16'h36A5);

        // parallel -> serial: everything held
        @(negedge clk);
        serial_mode = 1'b1;
        pin_m = 10'h001; pin_na = 3'd0; pin_nb = 1'b0; pin_p = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 active held", act_word(), 16'h36A5);
        do_rd(8'h00, rb);
        check("R3 shadow held", {8'h00, rb}, 16'h00A5);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][33:32])
                2'd0: do_wr(VEC[i][31:24], VEC[i][23:16]);
                2'd1: begin
                    do_rd(VEC[i][31:24], rb);
                    check($sformatf("vec%0d read", i), {8'h00, rb}, VEC[i][15:0]);
                end
                default: check($sformatf("vec%0d active", i), act_word(), VEC[i][15:0]);
            endcase
        end

        // R4 lock bit is live and read-only
        pll_lock = 1'b0;
        do_rd(8'h01, rb);
        check("R4 lock low", {8'h00, rb}, 16'h0000);
        pll_lock = 1'b1;
        do_rd(8'h01, rb);
        check("R4 lock high", {8'h00, rb}, 16'h0080);

        // serial -> parallel: pins take over at once
        @(negedge clk);
        pin_m = 10'h155; pin_na = 3'd2; pin_nb = 1'b0; pin_p = 1'b1;
        serial_mode = 1'b0;
        @(negedge clk);
        check("R2 serial to parallel", act_word(), 16'h4955);
        do_rd(8'h00, rb);
        check("R11 shadow tracks pins", {8'h00, rb}, 16'h0055);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset active", act_word(), 16'h0000);
        check("R1 mid-run reset rd_data", {8'h00, rd_data}, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule